// File: doc/BRIEF.md
# Parallel-Write Serial Configuration Loader

This block takes configuration bytes from a host processor over an asynchronous parallel bus and streams them out one bit per serial clock. A byte is captured when the host's write strobe rises. It first lands in a holding register and then moves into a shift register. The shift register sends the byte least significant bit first. Because there are two stages, the host can queue the next byte while the current one is still shifting. When bytes arrive in time, the serial stream runs without gaps from one byte into the next.

The host paces itself with a ready line. Ready drops as soon as a write ends. It returns only after the held byte has moved into the shift register. The host can also poll readiness with a status read, which returns the ready bit on the top data bit.

The write strobe comes from a different timing domain. It is brought into the serial clock domain through a two-stage synchroniser. As a result, the busy time after a write into an idle loader is about two to three serial clocks. After a write into a loader whose shifter has just been filled, it is about eight.

Top module: `cfg_ser_loader`

## Requirements
- R1: After a synchronous reset, `ready` is 1, `ser_out` is 1 (idle level) and `data_oe` is 0.
- R2: A write takes effect only while `sel_n`=0, `sel`=1 and `rstb_n`=1 at the rising edge of `wstb_n`. A strobe under any other select pattern leaves `ready` and `ser_out` unchanged.
- R3: The byte stored is the value on `data_in` at the rising edge of `wstb_n`. Changing `data_in` right after that edge has no effect on the serial output.
- R4: `ready` goes low as soon as an effective write ends. It stays low until the held byte has been moved into the shift register.
- R5: When the shifter is empty, the held byte moves into it on the third rising `clk` edge after the write strobe rises. `ser_out` shows bit 0 right after that edge and `ready` returns to 1.
- R6: The shifter presents one bit per `clk` cycle in order from bit 0 to bit 7. When no bits are left, `ser_out` is 1.
- R7: A byte that is already held moves in on the edge that retires the last bit of the previous byte. Bit 0 of the new byte therefore follows bit 7 of the old one in the very next cycle.
- R8: A status read (`sel_n`=0, `sel`=1, `rstb_n`=0, `wstb_n`=1) sets `data_oe` to 1 and returns `ready` on `data_out[7]`, with bits 6..0 at 0. At all other times `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset; also clears the strobe-domain toggle |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| wstb_n | input | 1 | Active-low write strobe; its rising edge captures data |
| rstb_n | input | 1 | Active-low read strobe for the status read |
| data_in | input | 8 | Parallel data from the host |
| data_out | output | 8 | Status value, valid while `data_oe` is 1 |
| data_oe | output | 1 | Bus drive enable; high only during a status read |
| ser_out | output | 1 | Serial data, bit 0 of each byte first |
| ready | output | 1 | High when a new byte may be written |

## Verification
On every clock, the assertions check three things: the shift count steps down by one, the first bit after a transfer is bit 0 of the held byte, and the output returns to the idle level once the shifter empties. They also check that `ready` only rises on a cycle that performed a transfer, and that a status read reports the current readiness on bit 7.

Some behaviours only the bench scenarios can show. These are the exact synchroniser latency from the strobe edge, the gapless hand-over between bytes, and the rejection of writes under wrong select patterns. The bench also shows that data changed just after the strobe edge is not picked up. It checks these by comparing every cycle against a behavioural queue model of the bit stream and of the ready line.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    localparam int CFG_BYTE_W  = 8;
    localparam int CFG_SYNC_N  = 2;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_op_e;

    // Both chip selects asserted (one active low, one active high).
    function automatic logic chip_selected(input logic sel_n, input logic sel);
        return (!sel_n) && sel;
    endfunction

    // Decode the bus strobes into an operation; both strobes low is not an operation.
    function automatic bus_op_e bus_decode(input logic sel_n, input logic sel,
                                           input logic wstb_n, input logic rstb_n);
        if (!chip_selected(sel_n, sel))   return BUS_IDLE;
        if (!wstb_n && rstb_n)            return BUS_WRITE;
        if (!rstb_n && wstb_n)            return BUS_READ;
        return BUS_IDLE;
    endfunction

endpackage

// File: rtl/cfg_ldr_capture.sv
module cfg_ldr_capture
    import cfg_ldr_pkg::*;
#(
    parameter int DATA_W = CFG_BYTE_W,
    parameter int SYNC_N = CFG_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wstb_n,
    input  logic              rstb_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              xfer,
    output logic              pend,
    output logic              busy,
    output logic [DATA_W-1:0] held
);

    logic              wr_tog_q;
    logic [DATA_W-1:0] hold_q;
    logic [SYNC_N-1:0] sync_q;
    logic              ack_q;
    logic              cap_en;

    // At the rising edge of the write strobe the strobe itself is already high,
    // so only the selects and the idle read strobe qualify the capture.
    assign cap_en = chip_selected(sel_n, sel) && rstb_n;

    always_ff @(posedge wstb_n or posedge rst) begin
        if (rst)         wr_tog_q <= 1'b0;
        else if (cap_en) wr_tog_q <= ~wr_tog_q;
    end

    always_ff @(posedge wstb_n) begin
        if (cap_en) hold_q <= data_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], wr_tog_q};
            if (xfer) ack_q <= ~ack_q;
        end
    end

    assign pend = sync_q[SYNC_N-1] ^ ack_q;
    assign busy = wr_tog_q ^ ack_q;
    assign held = hold_q;

endmodule

// File: rtl/cfg_ldr_shifter.sv
module cfg_ldr_shifter
    import cfg_ldr_pkg::*;
#(
    parameter int DATA_W = CFG_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend,
    input  logic [DATA_W-1:0] held,
    output logic              xfer,
    output logic              ser_out
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  left_q;

    // Hand-over happens when the shifter is empty or emitting its last bit.
    assign xfer = pend && (left_q <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (xfer) begin
            sh_q   <= held;
            left_q <= FULL;
        end else if (left_q != '0) begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - ONE;
        end
    end

    assign ser_out = (left_q != '0) ? sh_q[0] : 1'b1;

    // R6
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (left_q > ONE) |=> (left_q == $past(left_q) - ONE));

    // R7
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (ser_out == $past(held[0])));

    // R6
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer && left_q <= ONE) |=> ser_out);

endmodule

// File: rtl/cfg_ldr_status.sv
module cfg_ldr_status
    import cfg_ldr_pkg::*;
#(
    parameter int DATA_W = CFG_BYTE_W
) (
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wstb_n,
    input  logic              rstb_n,
    input  logic              busy,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    bus_op_e op;

    always_comb begin
        op       = bus_decode(sel_n, sel, wstb_n, rstb_n);
        data_oe  = (op == BUS_READ);
        data_out = '0;
        if (data_oe) data_out[DATA_W-1] = ~busy;
    end

endmodule

// File: rtl/cfg_ser_loader.sv
module cfg_ser_loader
    import cfg_ldr_pkg::*;
#(
    parameter int DATA_W = CFG_BYTE_W,
    parameter int SYNC_N = CFG_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wstb_n,
    input  logic              rstb_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ser_out,
    output logic              ready
);

    logic              pend;
    logic              busy;
    logic              xfer;
    logic [DATA_W-1:0] held;

    cfg_ldr_capture #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .sel_n   (sel_n),
        .sel     (sel),
        .wstb_n  (wstb_n),
        .rstb_n  (rstb_n),
        .data_in (data_in),
        .xfer    (xfer),
        .pend    (pend),
        .busy    (busy),
        .held    (held)
    );

    cfg_ldr_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .held    (held),
        .xfer    (xfer),
        .ser_out (ser_out)
    );

    cfg_ldr_status #(.DATA_W(DATA_W)) u_status (
        .sel_n    (sel_n),
        .sel      (sel),
        .wstb_n   (wstb_n),
        .rstb_n   (rstb_n),
        .busy     (busy),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    assign ready = ~busy;

    // R4
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(xfer));

    // R8
    status_d7_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (data_out[DATA_W-1] == ready));

endmodule

// File: tb/cfg_ser_loader_bench.sv
`timescale 1ns/100ps
module cfg_ser_loader_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       sel_n = 1'b1;
    logic       sel = 1'b0;
    logic       wstb_n = 1'b1;
    logic       rstb_n = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       ser_out;
    logic       ready;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Behavioural model: bits still to leave the shifter, and one held byte.
    bit         sq[$];
    bit         pend_v   = 1'b0;
    int         pend_age = 0;
    logic [7:0] pend_byte = 8'h00;

    cfg_ser_loader u_cfg_ser_loader (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .wstb_n(wstb_n),
        .rstb_n(rstb_n), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .ser_out(ser_out), .ready(ready)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // One clock edge: advance the model, then compare 1 ns after the edge.
    task automatic tick(string req);
        bit elig;
        int nb;
        @(posedge clk);
        elig = pend_v && (pend_age >= 2);
        if (pend_v) pend_age++;
        nb = sq.size();
        if (nb > 0) void'(sq.pop_front());
        if (elig && nb <= 1) begin
            for (int i = 0; i < 8; i++) sq.push_back(pend_byte[i]);
            pend_v = 1'b0;
        end
        #1;
        chk(req,  "ser_out", {7'b0, ser_out}, {7'b0, (sq.size() > 0) ? sq[0] : 1'b1});
        chk("R4", "ready",   {7'b0, ready},   {7'b0, !pend_v});
        chk("R8", "data_oe idle", {7'b0, data_oe}, 8'h00);
    endtask

    // Called 1 ns after an edge; strobe falls at +1.5, rises at +3.
    task automatic host_write(logic [7:0] b, logic s_n, logic s, logic r_n, string req);
        bit eff;
        eff = (s_n == 1'b0) && (s == 1'b1) && (r_n == 1'b1);
        #0.5;
        data_in = b; sel_n = s_n; sel = s; rstb_n = r_n; wstb_n = 1'b0;
        #1.5;
        wstb_n = 1'b1;
        #0.2;
        data_in = ~b;                          // R3: bus changes right after the edge
        #0.3;
        sel_n = 1'b1; sel = 1'b0; rstb_n = 1'b1;
        if (eff) begin
            pend_v = 1'b1; pend_age = 0; pend_byte = b;
        end
        chk(req, "ready after strobe", {7'b0, ready}, {7'b0, !pend_v});
    endtask

    task automatic host_read(logic s_n, logic s, string req);
        bit eff;
        eff = (s_n == 1'b0) && (s == 1'b1);
        #0.5;
        sel_n = s_n; sel = s; rstb_n = 1'b0;
        #1;
        chk(req, "data_oe", {7'b0, data_oe}, {7'b0, eff});
        if (eff) chk(req, "status", data_out, {!pend_v, 7'b0});
        #0.5;
        sel_n = 1'b1; sel = 1'b0; rstb_n = 1'b1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        chk("R1", "ready",   {7'b0, ready},   8'h01);
        chk("R1", "ser_out", {7'b0, ser_out}, 8'h01);
        chk("R1", "data_oe", {7'b0, data_oe}, 8'h00);
        tick("R1");

        // R8: idle status read shows ready on bit 7
        host_read(1'b0, 1'b1, "R8");
        host_read(1'b1, 1'b1, "R8");
        tick("R8");

        // R5, R6, R3: single write into an empty loader
        host_write(8'hA5, 1'b0, 1'b1, 1'b1, "R4");
        for (int i = 0; i < 12; i++) tick("R5");

        // R2: strobes with wrong select patterns are ignored
        host_write(8'h0F, 1'b1, 1'b1, 1'b1, "R2");
        tick("R2");
        host_write(8'hF0, 1'b0, 1'b0, 1'b1, "R2");
        tick("R2");
        host_write(8'h55, 1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 5; i++) tick("R2");

        // R7: next byte written while the shifter is full, gapless hand-over
        host_write(8'h3C, 1'b0, 1'b1, 1'b1, "R4");
        while (pend_v) tick("R5");
        host_write(8'hC1, 1'b0, 1'b1, 1'b1, "R4");
        tick("R7");
        host_read(1'b0, 1'b1, "R8");           // busy: bit 7 reads 0
        for (int i = 0; i < 20; i++) tick("R7");

        // R6, R7: stream of bytes, each written as soon as ready returns
        for (int k = 0; k < 8; k++) begin
            host_write(8'((k * 37 + 11) & 8'hFF), 1'b0, 1'b1, 1'b1, "R4");
            while (pend_v) tick("R7");
        end
        for (int i = 0; i < 12; i++) tick("R6");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule